// File: doc/BRIEF.md
# Physically Tagged Instruction Cache Lookup

This block is the tag and control section of a four-way set-associative instruction cache. A fetch presents an effective address together with a physical tag, which a translation unit running alongside produces in the same cycle. The set is chosen from the untranslated address bits, and the stored tags are compared against the supplied physical tag. A hit returns the addressed word, the hit way and a hit flag one cycle later.

On a miss, the block picks a victim way in the set and requests an aligned 32-byte line fill. It accepts eight data beats and writes them into the victim way. It then answers the stalled fetch with the word that was asked for. Each block holds eight 32-bit words and has 128 sets. A line therefore never straddles a translation page.

Bit numbering follows the big-endian convention, where bit 0 is the most significant bit of the 32-bit address. In the RTL these bits map as follows:
- Bits 27–31 are `addr[4:0]`, the byte in the line.
- Bits 20–26 are `addr[11:5]`, the set.
- Bits 0–19 are the 20-bit physical tag.

Top module: `icache_lookup`

## Requirements
- R1: After reset, `req_ready` is 1, `resp_valid`, `fill_req_valid` and `fill_ready` are 0, and every line is invalid, so the first fetch to any set misses.
- R2: A fetch is accepted when `req_valid` and `req_ready` are both high. The set index is `req_addr[11:5]` (big-endian bits 20–26) and the word is `req_addr[4:2]`. On a hit, the next cycle shows `resp_valid`=1, `resp_hit`=1, the hit way on `resp_way`, and the stored word on `resp_data`.
- R3: On a miss, `fill_req_valid` rises one cycle after acceptance with `fill_req_addr` = {physical tag, index, 5'b00000}. Both stay stable until `fill_req_ready` is seen high.
- R4: The fill is accepted as eight beats on `fill_valid`/`fill_ready`, word 0 first. `fill_ready` is high only between the fill handshake and the eighth beat. `req_ready` stays low from the miss until the eighth beat, so the filling line cannot be hit early.
- R5: The cycle after the eighth beat shows `resp_valid`=1, `resp_hit`=0, the victim way on `resp_way`, and the requested word from the fill on `resp_data`.
- R6: If the set has an invalid way, the victim is the lowest-numbered invalid way.
- R7: When all four ways are valid, the victim is the least-recently used way. Every hit and every completed fill makes its way the most recently used.
- R8: `inv_all`, when sampled in an idle cycle, clears every valid bit at that edge and restores the reset LRU order. `req_ready` is 0 during that cycle.
- R9: Hit detection compares only the supplied physical tag. `req_addr[31:12]` has no effect, so a matching physical tag hits whatever those bits hold, and a different physical tag misses even if those bits equal a stored tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Fetch request valid |
| req_ready | output | 1 | Fetch can be accepted |
| req_addr | input | 32 | Fetch effective address |
| req_ptag | input | 20 | Physical tag from translation |
| inv_all | input | 1 | Invalidate every line |
| resp_valid | output | 1 | Fetch result valid |
| resp_hit | output | 1 | 1 on a hit, 0 for a filled miss |
| resp_way | output | 2 | Way that holds the line |
| resp_data | output | 32 | Fetched word |
| fill_req_valid | output | 1 | Line fill request valid |
| fill_req_ready | input | 1 | Line fill request taken |
| fill_req_addr | output | 32 | Line-aligned fill address |
| fill_valid | input | 1 | Fill beat valid |
| fill_ready | output | 1 | Fill beat accepted |
| fill_data | input | 32 | Fill beat word |

## Verification
The hardest case to reach from the ports is a true LRU eviction. It needs one set filled completely, with a reordering of recency that differs from the fill order. The stimulus fills all four ways of one set and then hits the oldest way to move it to the front. It then misses twice with new tags. The victims, way 1 and then way 2, can only come from correct age tracking. A later invalidate followed by misses confirms that both the valid bits and the age order were reset.

// File: rtl/icache_pkg.sv
package icache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FREQ = 2'd1,
    ST_FILL = 2'd2
  } fill_st_e;
endpackage

// File: rtl/icache_tag_store.sv
module icache_tag_store #(
  parameter int SETS  = 128,
  parameter int WAYS  = 4,
  parameter int TAG_W = 20,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [TAG_W-1:0] rd_tag,
  output logic [WAYS-1:0]  hit_vec,
  output logic [WAYS-1:0]  set_valid,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [WAY_W-1:0] wr_way,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             clr
);
  logic [WAYS-1:0]  vld_q [SETS];
  logic [TAG_W-1:0] tag_q [SETS][WAYS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else if (clr) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else if (wr_en) begin
      vld_q[wr_idx][wr_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_idx][wr_way] <= wr_tag;
  end

  always_comb begin
    set_valid = vld_q[rd_idx];
    for (int w = 0; w < WAYS; w++)
      hit_vec[w] = vld_q[rd_idx][w] && (tag_q[rd_idx][w] == rd_tag);
  end

  p_single_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
  p_clear_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (vld_q[$past(rd_idx)] == '0) && (vld_q[$past(wr_idx)] == '0));
endmodule

// File: rtl/icache_lru.sv
module icache_lru #(
  parameter int SETS = 128,
  parameter int WAYS = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [WAYS-1:0]  rd_valid,
  output logic [WAY_W-1:0] victim,
  input  logic             touch,
  input  logic [IDX_W-1:0] t_idx,
  input  logic [WAY_W-1:0] t_way,
  input  logic             clr
);
  // age 0 = most recent, WAYS-1 = least recent
  logic [WAY_W-1:0] age_q [SETS][WAYS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
    end else if (clr) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
    end else if (touch) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == t_way)
          age_q[t_idx][w] <= '0;
        else if (age_q[t_idx][w] < age_q[t_idx][t_way])
          age_q[t_idx][w] <= age_q[t_idx][w] + 1'b1;
      end
    end
  end

  always_comb begin
    logic found;
    found  = 1'b0;
    victim = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!found && !rd_valid[w]) begin
        victim = WAY_W'(w);
        found  = 1'b1;
      end
    end
    if (!found) begin
      for (int w = 0; w < WAYS; w++)
        if (age_q[rd_idx][w] == WAY_W'(WAYS-1)) victim = WAY_W'(w);
    end
  end

  p_touch_mru_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (touch && !clr) |=> age_q[$past(t_idx)][$past(t_way)] == '0);
  p_invalid_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid != '1) |-> !rd_valid[victim]);
endmodule

// File: rtl/icache_data_ram.sv
module icache_data_ram #(
  parameter int DEPTH  = 4096,
  parameter int DATA_W = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/icache_lookup.sv
module icache_lookup
  import icache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WAYS   = 4,
  parameter int SETS   = 128,
  parameter int WORDS  = 8,
  localparam int IDX_W  = $clog2(SETS),
  localparam int WORD_W = $clog2(WORDS),
  localparam int BYTE_W = $clog2(DATA_W/8),
  localparam int OFF_W  = WORD_W + BYTE_W,
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W,
  localparam int WAY_W  = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [TAG_W-1:0]  req_ptag,
  input  logic              inv_all,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic [WAY_W-1:0]  resp_way,
  output logic [DATA_W-1:0] resp_data,
  output logic              fill_req_valid,
  input  logic              fill_req_ready,
  output logic [ADDR_W-1:0] fill_req_addr,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic [DATA_W-1:0] fill_data
);
  localparam int RAM_AW = IDX_W + WAY_W + WORD_W;

  fill_st_e state_q, state_d;

  logic [IDX_W-1:0]  req_idx;
  logic [WORD_W-1:0] req_word;
  logic [IDX_W-1:0]  m_idx_q;
  logic [WORD_W-1:0] m_word_q;
  logic [TAG_W-1:0]  m_tag_q;
  logic [WAY_W-1:0]  m_way_q;
  logic [WORD_W-1:0] beat_q, beat_d;
  logic [WAYS-1:0]   hit_vec, set_valid;
  logic              hit_any;
  logic [WAY_W-1:0]  hit_way, victim;
  logic              accept, lookup_hit, lookup_miss, inv_clr;
  logic              beat_acc, last_beat;
  logic              touch;
  logic [IDX_W-1:0]  touch_idx;
  logic [WAY_W-1:0]  touch_way;
  logic [DATA_W-1:0] rd_word;
  logic              resp_valid_d, resp_en, data_en;
  logic [DATA_W-1:0] resp_data_d;
  logic              unused_addr_bits;

  assign req_idx  = req_addr[OFF_W +: IDX_W];
  assign req_word = req_addr[BYTE_W +: WORD_W];
  assign unused_addr_bits = ^{req_addr[ADDR_W-1:OFF_W+IDX_W], req_addr[BYTE_W-1:0]};

  // handshake and control decode
  assign req_ready   = (state_q == ST_IDLE) && !inv_all;
  assign inv_clr     = (state_q == ST_IDLE) && inv_all;
  assign accept      = req_valid && req_ready;
  assign lookup_hit  = accept && hit_any;
  assign lookup_miss = accept && !hit_any;
  assign fill_ready  = (state_q == ST_FILL);
  assign beat_acc    = fill_valid && fill_ready;
  assign last_beat   = beat_acc && (beat_q == WORD_W'(WORDS-1));
  assign fill_req_valid = (state_q == ST_FREQ);
  assign fill_req_addr  = {m_tag_q, m_idx_q, {OFF_W{1'b0}}};

  always_comb begin
    hit_any = |hit_vec;
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (hit_vec[w]) hit_way = WAY_W'(w);
  end

  // next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (lookup_miss)    state_d = ST_FREQ;
      ST_FREQ: if (fill_req_ready) state_d = ST_FILL;
      ST_FILL: if (last_beat)      state_d = ST_IDLE;
      default:                     state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    beat_d = beat_q;
    if (lookup_miss)   beat_d = '0;
    else if (beat_acc) beat_d = beat_q + 1'b1;
  end

  assign resp_valid_d = lookup_hit || last_beat;
  assign resp_en      = resp_valid_d;
  assign data_en      = lookup_hit || (beat_acc && (beat_q == m_word_q));
  assign resp_data_d  = lookup_hit ? rd_word : fill_data;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      beat_q     <= '0;
      resp_valid <= 1'b0;
    end else begin
      state_q    <= state_d;
      beat_q     <= beat_d;
      resp_valid <= resp_valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_idx_q  <= '0;
      m_word_q <= '0;
      m_tag_q  <= '0;
      m_way_q  <= '0;
    end else if (lookup_miss) begin
      m_idx_q  <= req_idx;
      m_word_q <= req_word;
      m_tag_q  <= req_ptag;
      m_way_q  <= victim;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_hit <= 1'b0;
      resp_way <= '0;
    end else if (resp_en) begin
      resp_hit <= lookup_hit;
      resp_way <= lookup_hit ? hit_way : m_way_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       resp_data <= '0;
    else if (data_en) resp_data <= resp_data_d;
  end

  // recency update source
  assign touch     = lookup_hit || last_beat;
  assign touch_idx = lookup_hit ? req_idx : m_idx_q;
  assign touch_way = lookup_hit ? hit_way : m_way_q;

  icache_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_idx    (req_idx),
    .rd_tag    (req_ptag),
    .hit_vec   (hit_vec),
    .set_valid (set_valid),
    .wr_en     (last_beat),
    .wr_idx    (m_idx_q),
    .wr_way    (m_way_q),
    .wr_tag    (m_tag_q),
    .clr       (inv_clr)
  );

  icache_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (req_idx),
    .rd_valid (set_valid),
    .victim   (victim),
    .touch    (touch),
    .t_idx    (touch_idx),
    .t_way    (touch_way),
    .clr      (inv_clr)
  );

  icache_data_ram #(.DEPTH(SETS*WAYS*WORDS), .DATA_W(DATA_W)) u_data (
    .clk   (clk),
    .we    (beat_acc),
    .waddr (RAM_AW'({m_idx_q, m_way_q, beat_q})),
    .wdata (fill_data),
    .raddr (RAM_AW'({req_idx, hit_way, req_word})),
    .rdata (rd_word)
  );

  p_fill_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req_valid && !fill_req_ready) |=> (fill_req_valid && $stable(fill_req_addr)));
  p_hit_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_hit |=> (resp_valid && resp_hit && resp_way == $past(hit_way)));
  p_fill_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |=> (resp_valid && !resp_hit && req_ready == !inv_all));
  p_no_accept_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_ready |-> !req_ready);
endmodule

// File: tb/icache_lookup_tb.sv
`timescale 1ns/1ps
module icache_lookup_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready;
  logic [31:0] req_addr;
  logic [19:0] req_ptag;
  logic        inv_all;
  logic        resp_valid, resp_hit;
  logic [1:0]  resp_way;
  logic [31:0] resp_data;
  logic        fill_req_valid, fill_req_ready;
  logic [31:0] fill_req_addr;
  logic        fill_valid, fill_ready;
  logic [31:0] fill_data;

  always #2.5 clk = ~clk;

  icache_lookup u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_ptag(req_ptag), .inv_all(inv_all),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_way(resp_way),
    .resp_data(resp_data), .fill_req_valid(fill_req_valid),
    .fill_req_ready(fill_req_ready), .fill_req_addr(fill_req_addr),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_data(fill_data)
  );

  typedef struct {
    logic        hit;
    logic [1:0]  way;
    logic [31:0] data;
    string       rq;
  } exp_t;

  exp_t        sb[$];
  logic [31:0] fq[$];
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  function automatic logic [31:0] fdata(logic [31:0] base, int w);
    return (base + 32'(w * 4)) ^ 32'h5A5A_5A5A;
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic issue(input logic [6:0] idx, input logic [2:0] word,
                       input logic [19:0] ptag, input logic [19:0] hi,
                       input logic ehit, input logic [1:0] eway, input string rq);
    exp_t e;
    logic [31:0] base;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    base      = {ptag, idx, 5'b0};
    req_addr  = {hi, idx, word, 2'b00};
    req_ptag  = ptag;
    req_valid = 1'b1;
    e.hit = ehit; e.way = eway; e.data = fdata(base, int'(word)); e.rq = rq;
    sb.push_back(e);
    if (!ehit) fq.push_back(base);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic do_inv();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    inv_all = 1'b1;
    #0.5 chk(req_ready == 1'b0, "R8", "req_ready during invalidate", 32'(req_ready), 0);
    @(posedge clk);
    #1 inv_all = 1'b0;
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (resp_valid) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R2", "unexpected response", 32'(resp_way), 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(resp_hit == e.hit, e.rq, "resp_hit", 32'(resp_hit), 32'(e.hit));
          chk(resp_way == e.way, e.rq, "resp_way", 32'(resp_way), 32'(e.way));
          chk(resp_data == e.data, e.rq, "resp_data", resp_data, e.data);
        end
      end
    end
  end

  // line fill responder
  initial begin
    fill_req_ready = 1'b0;
    fill_valid     = 1'b0;
    fill_data      = '0;
    forever begin
      @(negedge clk);
      if (rst_n && fill_req_valid) begin
        logic [31:0] base;
        base = (fq.size() != 0) ? fq.pop_front() : 32'hDEAD_BEEF;
        chk(fill_req_addr == base, "R3", "fill_req_addr", fill_req_addr, base);
        @(negedge clk);
        chk(fill_req_valid && fill_req_addr == base, "R3", "fill request held",
            fill_req_addr, base);
        fill_req_ready = 1'b1;
        @(negedge clk);
        fill_req_ready = 1'b0;
        for (int w = 0; w < 8; w++) begin
          fill_valid = 1'b1;
          fill_data  = fdata(base, w);
          chk(fill_ready == 1'b1, "R4", "fill_ready during beats", 32'(fill_ready), 1);
          chk(req_ready == 1'b0, "R4", "req_ready during fill", 32'(req_ready), 0);
          @(negedge clk);
        end
        fill_valid = 1'b0;
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  localparam logic [6:0]  S5 = 7'd5;
  localparam logic [19:0] T0 = 20'h10000, T1 = 20'h10001, T2 = 20'h10002,
                          T3 = 20'h10003, T4 = 20'h10004;

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_ptag = '0; inv_all = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1", "req_ready", 32'(req_ready), 1);
    chk(resp_valid == 1'b0, "R1", "resp_valid", 32'(resp_valid), 0);
    chk(fill_req_valid == 1'b0, "R1", "fill_req_valid", 32'(fill_req_valid), 0);
    chk(fill_ready == 1'b0, "R1", "fill_ready", 32'(fill_ready), 0);

    issue(S5, 3'd3, T0, T0, 1'b0, 2'd0, "R5");   // first miss, R1/R6
    issue(S5, 3'd7, T0, T0, 1'b1, 2'd0, "R2");
    issue(S5, 3'd0, T0, 20'hFFFFF, 1'b1, 2'd0, "R9"); // junk upper bits
    issue(S5, 3'd1, T1, T1, 1'b0, 2'd1, "R6");
    issue(S5, 3'd2, T2, T2, 1'b0, 2'd2, "R6");
    issue(S5, 3'd7, T3, T3, 1'b0, 2'd3, "R6");
    issue(S5, 3'd2, T0, T0, 1'b1, 2'd0, "R7");   // way0 to front, way1 oldest
    issue(S5, 3'd4, T4, T4, 1'b0, 2'd1, "R7");   // evicts way1
    issue(S5, 3'd5, T1, T1, 1'b0, 2'd2, "R7");   // evicts way2
    issue(S5, 3'd6, T4, T4, 1'b1, 2'd1, "R7");   // filled line is stored
    issue(S5, 3'd0, T3, T3, 1'b1, 2'd3, "R2");

    do_inv();
    issue(S5, 3'd1, T3, T3, 1'b0, 2'd0, "R8");   // all invalid again
    issue(S5, 3'd2, T0, T0, 1'b0, 2'd1, "R8");
    issue(S5, 3'd3, 20'h00BAD, T3, 1'b0, 2'd2, "R9"); // upper bits equal T3, tag differs
    issue(7'd0, 3'd7, 20'h0ABCD, 20'h0ABCD, 1'b0, 2'd0, "R2");
    issue(7'd127, 3'd0, 20'hFEDCB, 20'hFEDCB, 1'b0, 2'd0, "R2");
    issue(7'd127, 3'd5, 20'hFEDCB, 20'hFEDCB, 1'b1, 2'd0, "R2");
    issue(7'd0, 3'd7, 20'h0ABCD, 20'h0ABCD, 1'b1, 2'd0, "R2");

    while (sb.size() != 0 || fq.size() != 0 || !req_ready) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(resp_valid == 1'b0, "R2", "no extra response", 32'(resp_valid), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule